// File: doc/BRIEF.md
# Host Bridge Inbound Window Translator

This block sits inside a host-to-PCI bridge. It keeps the bridge's control registers and maps CPU accesses that land in one of three inbound memory windows onto PCI memory-space addresses. Software programs a base register for each window through a 32-bit register port. The address decode that sits in front of the block supplies a window number and a byte offset within that window on the translation port. The block answers in the same cycle with the PCI address and a hit flag.

A static strap input picks one of two board variants. In the nibble variant, the low four bits of a base register become PCI address bits [31:28]. In the masked variant, the base register is cleared below the window size and used directly. Each variant has its own set of window sizes, and the sizes are parameters. An offset that reaches past its window gives a miss.

Top module: `hbw_xlate`

## Requirements
- R1: After reset every register reads back as zero, so all three windows start translating from PCI base 0.
- R2: Register byte offsets: window bases at 0x00, 0x04, 0x08 (window n at 4*n); identity at 0x0C; flags at 0x10; secondary maps at 0x14, 0x18, 0x1C. A full write followed by a full read of the same offset returns the written word.
- R3: A read from an offset outside that map, including one with address bits [1:0] not zero, returns 0. A write to such an offset changes no register.
- R4: Only accesses with `reg_full` high act. A write with `reg_full` low is dropped, and a read with `reg_full` low returns 0.
- R5: With `mode_alt` low (nibble variant), the window base is base register bits [3:0] placed at address bits [31:28], and the PCI address is that base plus the offset (modulo 2^32).
- R6: With `mode_alt` high (masked variant), the window base is the base register AND NOT (window size - 1), and the PCI address is that base plus the offset.
- R7: Window sizes with `mode_alt` low are 0x0C000000, 0x10000000 and 0x10000000 for windows 0, 1 and 2. An offset equal to or above the size gives `xl_hit` low and `xl_addr` zero.
- R8: Window sizes with `mode_alt` high are 0x01000000, 0x04000000 and 0x08000000, with the same miss behaviour as in R7.
- R9: A translation in the same cycle as a write to its base register uses the old base. From the next cycle on, the new base applies.
- R10: Window index 3 is not a window. It always gives `xl_hit` low and `xl_addr` zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_alt | input | 1 | Variant strap: 0 nibble base, 1 masked base |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_full | input | 1 | Access is a full 32-bit word |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| xl_win | input | 2 | Window index to translate |
| xl_off | input | 32 | Byte offset within the window |
| xl_addr | output | 32 | Translated PCI address, zero on a miss |
| xl_hit | output | 1 | Offset lies inside a valid window |

## Verification
The hardest case to reach from the ports is the cycle where a base register write and a translation through that same window happen together. The driver holds the translation inputs steady across a write to window 0's base. The scoreboard expects the old address in the write cycle and the new one in the following cycle. The other hard cases are the size edges: offsets of exactly size - 1 and exactly size are applied in both variants. These include a base whose sum wraps to 0xFFFFFFFF, and base registers that carry junk above the bits each variant uses.

// File: rtl/hbw_pkg.sv
`timescale 1ns/1ps
package hbw_pkg;
   localparam int REG_STRIDE = 4;
   localparam int STRIDE_SH  = 2;

   typedef enum logic [2:0] {
      DEC_NONE,
      DEC_BASE,
      DEC_IDENT,
      DEC_FLAGS,
      DEC_SEC
   } reg_dec_e;
endpackage

// File: rtl/hbw_regs.sv
`timescale 1ns/1ps
module hbw_regs
   import hbw_pkg::*;
#(
   parameter int NUM_WIN = 3,
   parameter int DW      = 32,
   parameter int AW      = 12
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           reg_rd,
   input  logic                           reg_wr,
   input  logic                           reg_full,
   input  logic [AW-1:0]                  reg_addr,
   input  logic [DW-1:0]                  reg_wdata,
   output logic [DW-1:0]                  reg_rdata,
   output logic [NUM_WIN-1:0][DW-1:0]     win_base
);
   localparam int IW        = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
   localparam int BASE_GRP  = 0;
   localparam int IDENT_OFS = BASE_GRP + NUM_WIN * REG_STRIDE;
   localparam int FLAGS_OFS = IDENT_OFS + REG_STRIDE;
   localparam int SEC_GRP   = FLAGS_OFS + REG_STRIDE;
   localparam int MAP_END   = SEC_GRP + NUM_WIN * REG_STRIDE;

   reg_dec_e          dec;
   logic [IW-1:0]     idx;
   logic [AW-1:0]     rel;
   logic              wr_ok;
   logic [DW-1:0]     ident_q;
   logic [DW-1:0]     flags_q;
   logic [NUM_WIN-1:0][DW-1:0] base_q;
   logic [NUM_WIN-1:0][DW-1:0] sec_q;

   // decode of the byte offset into register kind and group index
   always_comb begin
      dec = DEC_NONE;
      rel = '0;
      if (reg_addr[STRIDE_SH-1:0] == '0) begin
         if (reg_addr < AW'(IDENT_OFS)) begin
            dec = DEC_BASE;
            rel = reg_addr - AW'(BASE_GRP);
         end else if (reg_addr == AW'(IDENT_OFS)) begin
            dec = DEC_IDENT;
         end else if (reg_addr == AW'(FLAGS_OFS)) begin
            dec = DEC_FLAGS;
         end else if (reg_addr >= AW'(SEC_GRP) && reg_addr < AW'(MAP_END)) begin
            dec = DEC_SEC;
            rel = reg_addr - AW'(SEC_GRP);
         end
      end
   end

   assign idx   = rel[IW+STRIDE_SH-1:STRIDE_SH];
   assign wr_ok = reg_wr && reg_full;

   for (genvar i = 0; i < NUM_WIN; i++) begin : g_win_regs
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            base_q[i] <= '0;
            sec_q[i]  <= '0;
         end else if (wr_ok && idx == IW'(i)) begin
            if (dec == DEC_BASE) base_q[i] <= reg_wdata;
            if (dec == DEC_SEC)  sec_q[i]  <= reg_wdata;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ident_q <= '0;
         flags_q <= '0;
      end else if (wr_ok) begin
         if (dec == DEC_IDENT) ident_q <= reg_wdata;
         if (dec == DEC_FLAGS) flags_q <= reg_wdata;
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_rd && reg_full) begin
         case (dec)
            DEC_BASE:  reg_rdata = base_q[idx];
            DEC_IDENT: reg_rdata = ident_q;
            DEC_FLAGS: reg_rdata = flags_q;
            DEC_SEC:   reg_rdata = sec_q[idx];
            default:   reg_rdata = '0;
         endcase
      end
   end

   assign win_base = base_q;
endmodule

// File: rtl/hbw_window.sv
`timescale 1ns/1ps
module hbw_window #(
   parameter int           DW       = 32,
   parameter int           NIB_W    = 4,
   parameter logic [DW-1:0] PRI_SIZE = 32'h1000_0000,
   parameter logic [DW-1:0] ALT_SIZE = 32'h0100_0000
) (
   input  logic          mode_alt,
   input  logic [DW-1:0] base_reg,
   input  logic [DW-1:0] off,
   output logic [DW-1:0] pci_addr,
   output logic          in_range
);
   localparam int          NIB_SH   = DW - NIB_W;
   localparam logic [DW-1:0] ALT_MASK = ~(ALT_SIZE - 1'b1);

   if (ALT_SIZE == '0 || (ALT_SIZE & (ALT_SIZE - 1'b1)) != '0) begin : g_bad_alt
      $error("hbw_window: ALT_SIZE must be a nonzero power of two");
   end
   if (PRI_SIZE == '0 || 64'(PRI_SIZE) > (64'd1 << NIB_SH)) begin : g_bad_pri
      $error("hbw_window: PRI_SIZE must be nonzero and fit below the nibble");
   end

   logic [DW-1:0] size_sel;
   logic [DW-1:0] pri_base;
   logic [DW-1:0] alt_base;
   logic [DW-1:0] base_sel;

   assign pri_base = {base_reg[NIB_W-1:0], {NIB_SH{1'b0}}};
   assign alt_base = base_reg & ALT_MASK;
   assign size_sel = mode_alt ? ALT_SIZE : PRI_SIZE;
   assign base_sel = mode_alt ? alt_base : pri_base;
   assign in_range = (off < size_sel);
   assign pci_addr = in_range ? (base_sel + off) : '0;
endmodule

// File: rtl/hbw_xlate.sv
`timescale 1ns/1ps
module hbw_xlate #(
   parameter int NUM_WIN = 3,
   parameter int DW      = 32,
   parameter int AW      = 12,
   parameter int NIB_W   = 4,
   parameter logic [NUM_WIN-1:0][DW-1:0] PRI_SIZES =
      {32'h1000_0000, 32'h1000_0000, 32'h0C00_0000},
   parameter logic [NUM_WIN-1:0][DW-1:0] ALT_SIZES =
      {32'h0800_0000, 32'h0400_0000, 32'h0100_0000}
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 mode_alt,
   input  logic                 reg_rd,
   input  logic                 reg_wr,
   input  logic                 reg_full,
   input  logic [AW-1:0]        reg_addr,
   input  logic [DW-1:0]        reg_wdata,
   output logic [DW-1:0]        reg_rdata,
   input  logic [((NUM_WIN > 1) ? $clog2(NUM_WIN) : 1)-1:0] xl_win,
   input  logic [DW-1:0]        xl_off,
   output logic [DW-1:0]        xl_addr,
   output logic                 xl_hit
);
   localparam int IW      = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
   localparam int MAP_LEN = (2 * NUM_WIN + 2) * hbw_pkg::REG_STRIDE;

   if (NUM_WIN < 2) begin : g_bad_win
      $error("hbw_xlate: NUM_WIN must be at least 2");
   end
   if (NIB_W < 1 || NIB_W >= DW) begin : g_bad_nib
      $error("hbw_xlate: NIB_W must lie between 1 and DW-1");
   end
   if (MAP_LEN > (1 << AW)) begin : g_bad_aw
      $error("hbw_xlate: AW too narrow for the register map");
   end

   logic [NUM_WIN-1:0][DW-1:0] win_base;
   logic [NUM_WIN-1:0][DW-1:0] win_addr;
   logic [NUM_WIN-1:0]         win_in;

   hbw_regs #(.NUM_WIN(NUM_WIN), .DW(DW), .AW(AW)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_rd    (reg_rd),
      .reg_wr    (reg_wr),
      .reg_full  (reg_full),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .win_base  (win_base)
   );

   for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
      hbw_window #(
         .DW       (DW),
         .NIB_W    (NIB_W),
         .PRI_SIZE (PRI_SIZES[i]),
         .ALT_SIZE (ALT_SIZES[i])
      ) u_win (
         .mode_alt (mode_alt),
         .base_reg (win_base[i]),
         .off      (xl_off),
         .pci_addr (win_addr[i]),
         .in_range (win_in[i])
      );
   end

   always_comb begin
      xl_addr = '0;
      xl_hit  = 1'b0;
      if (32'(xl_win) < NUM_WIN) begin
         xl_addr = win_addr[xl_win];
         xl_hit  = win_in[xl_win];
      end
   end
endmodule

// File: rtl/hbw_xlate_chk.sv
`timescale 1ns/1ps
module hbw_xlate_chk #(
   parameter int NUM_WIN = 3,
   parameter int DW      = 32,
   parameter int AW      = 12,
   parameter int NIB_W   = 4,
   parameter logic [NUM_WIN-1:0][DW-1:0] PRI_SIZES = '0,
   parameter logic [NUM_WIN-1:0][DW-1:0] ALT_SIZES = '0
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 mode_alt,
   input logic                 reg_rd,
   input logic                 reg_wr,
   input logic                 reg_full,
   input logic [AW-1:0]        reg_addr,
   input logic [DW-1:0]        reg_wdata,
   input logic [DW-1:0]        reg_rdata,
   input logic [((NUM_WIN > 1) ? $clog2(NUM_WIN) : 1)-1:0] xl_win,
   input logic [DW-1:0]        xl_off,
   input logic [DW-1:0]        xl_addr,
   input logic                 xl_hit
);
   localparam int NIB_SH  = DW - NIB_W;
   localparam int MAP_END = (2 * NUM_WIN + 2) * hbw_pkg::REG_STRIDE;

   function automatic int min_alt_log2();
      int m;
      m = DW;
      for (int i = 0; i < NUM_WIN; i++)
         if ($clog2(ALT_SIZES[i]) < m) m = $clog2(ALT_SIZES[i]);
      return m;
   endfunction
   localparam int ALT_LOW = min_alt_log2();

   logic [DW-1:0] pri_keep;
   logic [DW-1:0] alt_keep;
   assign pri_keep = (DW'(1) << NIB_SH) - 1'b1;
   assign alt_keep = (DW'(1) << ALT_LOW) - 1'b1;

   // R7 / R8: a miss never presents an address
   assert_miss_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !xl_hit |-> xl_addr == '0);

   // R10: indices beyond the last window never hit
   assert_bad_win_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(xl_win) >= NUM_WIN) |-> !xl_hit);

   // R3: reads outside the map return zero
   assert_undef_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && (32'(reg_addr) >= MAP_END || reg_addr[1:0] != 2'b00))
      |-> reg_rdata == '0);

   // R4: non-full reads return zero
   assert_partial_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && !reg_full) |-> reg_rdata == '0);

   // R2: window 0 base reads back what was written the cycle before
   assert_base0_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_full && reg_addr == '0)
      |=> (!(reg_rd && reg_full && reg_addr == '0) || reg_rdata == $past(reg_wdata)));

   // R5: nibble variant keeps the offset bits below the nibble
   assert_pri_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_alt && xl_hit) |-> ((xl_addr & pri_keep) == (xl_off & pri_keep)));

   // R6: masked variant keeps the offset bits below the smallest window
   assert_alt_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_alt && xl_hit) |-> ((xl_addr & alt_keep) == (xl_off & alt_keep)));
endmodule

bind hbw_xlate hbw_xlate_chk #(
   .NUM_WIN   (NUM_WIN),
   .DW        (DW),
   .AW        (AW),
   .NIB_W     (NIB_W),
   .PRI_SIZES (PRI_SIZES),
   .ALT_SIZES (ALT_SIZES)
) u_chk (.*);

// File: tb/hbw_xlate_test.sv
`timescale 1ns/1ps
module hbw_xlate_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_alt = 1'b0;
   logic        reg_rd = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_full = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [1:0]  xl_win = '0;
   logic [31:0] xl_off = '0;
   logic [31:0] xl_addr;
   logic        xl_hit;

   int total = 0;
   int bad = 0;
   bit done = 0;

   // scoreboard queues: kind 0 = rdata, 1 = xl_addr, 2 = xl_hit
   string       q_req[$];
   int          q_kind[$];
   logic [31:0] q_exp[$];

   logic [31:0] shadow_base [3];

   always #2.5 clk = ~clk;

   hbw_xlate uut (
      .clk(clk), .rst_n(rst_n), .mode_alt(mode_alt),
      .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_full(reg_full),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .xl_win(xl_win), .xl_off(xl_off), .xl_addr(xl_addr), .xl_hit(xl_hit)
   );

   function automatic logic [32:0] model(bit alt, logic [31:0] breg, int win,
                                         logic [31:0] off);
      logic [31:0] pri_sz [3];
      logic [31:0] alt_sz [3];
      logic [31:0] sz;
      logic [31:0] base;
      pri_sz = '{32'h0C00_0000, 32'h1000_0000, 32'h1000_0000};
      alt_sz = '{32'h0100_0000, 32'h0400_0000, 32'h0800_0000};
      if (win > 2) return 33'd0;
      sz = alt ? alt_sz[win] : pri_sz[win];
      if (off >= sz) return 33'd0;
      base = alt ? (breg & ~(sz - 32'd1)) : {breg[3:0], 28'h0};
      return {1'b1, base + off};
   endfunction

   task automatic push(string req, int kind, logic [31:0] exp);
      q_req.push_back(req);
      q_kind.push_back(kind);
      q_exp.push_back(exp);
   endtask

   // monitor: compares every queued expectation shortly after the falling edge
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (q_kind.size() > 0) begin
            string       r;
            int          k;
            logic [31:0] e;
            logic [31:0] a;
            r = q_req.pop_front();
            k = q_kind.pop_front();
            e = q_exp.pop_front();
            a = (k == 0) ? reg_rdata : (k == 1) ? xl_addr : {31'd0, xl_hit};
            total++;
            if (a !== e) begin
               bad++;
               $display("FAIL %s kind=%0d actual=%h expected=%h", r, k, a, e);
            end
         end
      end
   end

   task automatic do_write(logic [11:0] addr, logic [31:0] data, bit full);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = addr; reg_wdata = data; reg_full = full;
      @(posedge clk);
      #1;
      reg_wr = 1'b0; reg_full = 1'b0;
      if (full && addr[1:0] == 2'b00 && addr < 12'h00C)
         shadow_base[addr[3:2]] = data;
   endtask

   task automatic check_read(logic [11:0] addr, bit full, logic [31:0] exp, string req);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = addr; reg_full = full;
      push(req, 0, exp);
      @(posedge clk);
      #1;
      reg_rd = 1'b0; reg_full = 1'b0;
   endtask

   task automatic check_xl(int win, logic [31:0] off, string req);
      logic [32:0] m;
      @(negedge clk);
      xl_win = 2'(win); xl_off = off;
      m = model(mode_alt, (win < 3) ? shadow_base[win] : 32'd0, win, off);
      push(req, 1, m[31:0]);
      push(req, 2, {31'd0, m[32]});
      @(posedge clk);
      #1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [32:0] m;
      for (int i = 0; i < 3; i++) shadow_base[i] = '0;
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state of all eight registers and of the translation
      for (int i = 0; i < 8; i++) check_read(12'(4 * i), 1'b1, 32'h0, "R1");
      check_xl(0, 32'h0000_0010, "R1");

      // R2: every register offset holds its own value
      do_write(12'h000, 32'hABCD_E005, 1'b1);
      do_write(12'h004, 32'h0000_000F, 1'b1);
      do_write(12'h008, 32'h0000_0003, 1'b1);
      do_write(12'h00C, 32'h1111_0C0C, 1'b1);
      do_write(12'h010, 32'h2222_1010, 1'b1);
      do_write(12'h014, 32'h3333_1414, 1'b1);
      do_write(12'h018, 32'h4444_1818, 1'b1);
      do_write(12'h01C, 32'h5555_1C1C, 1'b1);
      check_read(12'h000, 1'b1, 32'hABCD_E005, "R2");
      check_read(12'h004, 1'b1, 32'h0000_000F, "R2");
      check_read(12'h008, 1'b1, 32'h0000_0003, "R2");
      check_read(12'h00C, 1'b1, 32'h1111_0C0C, "R2");
      check_read(12'h010, 1'b1, 32'h2222_1010, "R2");
      check_read(12'h014, 1'b1, 32'h3333_1414, "R2");
      check_read(12'h018, 1'b1, 32'h4444_1818, "R2");
      check_read(12'h01C, 1'b1, 32'h5555_1C1C, "R2");

      // R3: undefined and misaligned offsets
      do_write(12'h020, 32'hDEAD_BEEF, 1'b1);
      do_write(12'h002, 32'hDEAD_BEEF, 1'b1);
      do_write(12'hFFC, 32'hDEAD_BEEF, 1'b1);
      check_read(12'h020, 1'b1, 32'h0, "R3");
      check_read(12'h002, 1'b1, 32'h0, "R3");
      check_read(12'h000, 1'b1, 32'hABCD_E005, "R3");
      check_read(12'h010, 1'b1, 32'h2222_1010, "R3");
      check_read(12'h01C, 1'b1, 32'h5555_1C1C, "R3");

      // R4: non-full accesses
      do_write(12'h004, 32'h0000_0007, 1'b0);
      check_read(12'h004, 1'b1, 32'h0000_000F, "R4");
      check_read(12'h004, 1'b0, 32'h0, "R4");

      // R5 / R7: nibble variant
      mode_alt = 1'b0;
      check_xl(0, 32'h0000_1234, "R5");
      check_xl(2, 32'h0800_0000, "R5");
      check_xl(0, 32'h0BFF_FFFF, "R7");
      check_xl(0, 32'h0C00_0000, "R7");
      check_xl(1, 32'h0FFF_FFFF, "R7");
      check_xl(1, 32'h1000_0000, "R7");
      check_xl(2, 32'hFFFF_FFFF, "R7");
      // R10: index 3
      check_xl(3, 32'h0000_0000, "R10");

      // R6 / R8: masked variant
      mode_alt = 1'b1;
      do_write(12'h004, 32'h1234_5678, 1'b1);
      do_write(12'h008, 32'hFFFF_FFFF, 1'b1);
      check_xl(0, 32'h0000_0042, "R6");
      check_xl(1, 32'h0000_0100, "R6");
      check_xl(0, 32'h00FF_FFFF, "R8");
      check_xl(0, 32'h0100_0000, "R8");
      check_xl(1, 32'h03FF_FFFF, "R8");
      check_xl(1, 32'h0400_0000, "R8");
      check_xl(2, 32'h07FF_FFFF, "R8");
      check_xl(2, 32'h0800_0000, "R8");
      check_xl(3, 32'h0000_0004, "R10");

      // R9: write and translate in the same cycle
      mode_alt = 1'b0;
      @(negedge clk);
      xl_win = 2'd0; xl_off = 32'h0000_0040;
      reg_wr = 1'b1; reg_full = 1'b1; reg_addr = 12'h000; reg_wdata = 32'h0000_0009;
      m = model(1'b0, shadow_base[0], 0, 32'h0000_0040);
      push("R9", 1, m[31:0]);
      @(posedge clk);
      #1;
      reg_wr = 1'b0; reg_full = 1'b0;
      shadow_base[0] = 32'h0000_0009;
      @(negedge clk);
      m = model(1'b0, shadow_base[0], 0, 32'h0000_0040);
      push("R9", 1, m[31:0]);
      @(posedge clk);
      #1;

      repeat (3) @(posedge clk);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule